// File: doc/BRIEF.md
# I2C Address Wake Receiver

This block lets a device that has stopped or slowed its main processor clock still answer a bus master. While the wake function is enabled, a START on the bus (SDA falling while SCL is high) asks the local oscillator to run. The block then shifts in the address byte on the slow clock. Once the byte, or the byte plus its acknowledge clock, has gone past, it raises two interrupt requests together and holds SCL low. Software then has time to bring its own clock up before it releases the bus.

If the start is judged too short, the block raises only the pin interrupt, captures nothing and goes back to idle. A STOP seen during reception also ends the attempt, and in that case no interrupt is raised. Both interrupt requests are sticky. Software clears each one separately with a one-cycle clear pulse.

Top module: `i2c_wake_rx`

## Requirements
- R1: After reset, `osc_req`, `pin_irq`, `bus_irq` and `scl_hold` are 0 and `addr_o` is 0x00.
- R2: While `wake_en` is 0, a START on the bus leaves `osc_req` at 0, and later SCL clocks raise no interrupt.
- R3: With `wake_en` at 1, an SDA falling edge while SCL is high sets `osc_req` one clock after the edge is seen.
- R4: The address is taken MSB first, one bit per SCL rising edge. At the interrupt, `addr_o` shows all eight bits, with the first bit received in bit 7.
- R5: With `ack_clk_en` at 0, the interrupts assert one clock after the SCL falling edge that ends the eighth address bit.
- R6: With `ack_clk_en` at 1, nothing fires at the end of the eighth bit. The interrupts assert one clock after the SCL falling edge that ends the ninth (acknowledge) clock.
- R7: `pin_irq` and `bus_irq` rise in the same clock cycle when an address is received.
- R8: `scl_hold` is 1 from the interrupt cycle until a `hold_release` pulse arrives. That pulse clears `scl_hold` and `osc_req` on the next clock.
- R9: If `start_ok` is 0 at the first SCL falling edge after the START, only `pin_irq` is set, `addr_o` is left unchanged, and `osc_req` returns to 0.
- R10: A STOP (SDA rising while SCL is high) during address shifting returns the block to idle with `osc_req` at 0 and no interrupt raised.
- R11: A pulse on `clr_pin_irq` or `clr_bus_irq` clears only its own request. A set arriving in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | slow receive clock |
| rst_n | input | 1 | asynchronous reset, active low |
| scl_i | input | 1 | synchronized SCL level |
| sda_i | input | 1 | synchronized SDA level |
| wake_en | input | 1 | enables wake reception |
| ack_clk_en | input | 1 | 1: fire after the acknowledge clock |
| start_ok | input | 1 | START met its hold time (sampled at first SCL fall) |
| hold_release | input | 1 | software pulse that frees SCL |
| clr_pin_irq | input | 1 | clear pulse for `pin_irq` |
| clr_bus_irq | input | 1 | clear pulse for `bus_irq` |
| osc_req | output | 1 | local oscillator run request |
| addr_o | output | 8 | last captured address byte |
| pin_irq | output | 1 | SCL/SDA pin interrupt request |
| bus_irq | output | 1 | bus interrupt request |
| scl_hold | output | 1 | drive SCL low |

## Verification
A state machine stuck outside idle shows at once as `osc_req` staying high after a STOP or a release. A state machine that never leaves idle shows as `osc_req` staying low one clock after the START. If the bit counter is off by one, the interrupts come one SCL period early or late, and that is visible at the first falling edge after the expected bit. A fault in the shift direction only shows in `addr_o` at the interrupt cycle, so each frame is checked there with asymmetric byte patterns.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_SHIFT = 3'd2,
    ST_ACK   = 3'd3,
    ST_HOLD  = 3'd4
  } wake_state_t;

  // Shift one bit in at the LSB end; the first bit received ends up at the MSB.
  function automatic logic [7:0] shift_msb_first(input logic [7:0] cur, input logic b);
    return {cur[6:0], b};
  endfunction

  // Interrupts fire on the SCL fall that ends either the last data bit or the ACK clock.
  function automatic logic fire_ready(input logic ack_en, input logic ack_clock_seen);
    return !ack_en || ack_clock_seen;
  endfunction
endpackage

// File: rtl/i2cw_edge.sv
module i2cw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = !scl_q && scl_i;
  assign scl_fall  = scl_q && !scl_i;
  assign start_evt = scl_q && scl_i && sda_q && !sda_i;
  assign stop_evt  = scl_q && scl_i && !sda_q && sda_i;
endmodule

// File: rtl/i2cw_shift.sv
module i2cw_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] data,
  output logic         full
);
  localparam int CW = $clog2(W + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      cnt  <= '0;
    end else if (clear) begin
      data <= '0;
      cnt  <= '0;
    end else if (shift_en && !full) begin
      data <= {data[W-2:0], bit_in};
      cnt  <= cnt + 1'b1;
    end
  end

  assign full = (cnt == CW'(W));

  // R4
  counter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (full || $past(clear)));
endmodule

// File: rtl/i2cw_irq.sv
module i2cw_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] req
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      req[i] <= 1'b0;
      else if (set[i]) req[i] <= 1'b1;
      else if (clr[i]) req[i] <= 1'b0;
    end

    // R11
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !req[i]);
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> req[i]);
  end
endmodule

// File: rtl/i2c_wake_rx.sv
module i2c_wake_rx
  import i2cw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wake_en,
  input  logic              ack_clk_en,
  input  logic              start_ok,
  input  logic              hold_release,
  input  logic              clr_pin_irq,
  input  logic              clr_bus_irq,
  output logic              osc_req,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pin_irq,
  output logic              bus_irq,
  output logic              scl_hold
);
  wake_state_t       state;
  logic              scl_rise, scl_fall, start_evt, stop_evt;
  logic              ack_seen;
  logic [ADDR_W-1:0] shift_data;
  logic              shift_full;
  logic              fire_evt, bad_start_evt, shift_en, shift_clr;
  logic [1:0]        irq_set, irq_clr, irq_req;

  i2cw_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign shift_en  = (state == ST_SHIFT) && scl_rise;
  assign shift_clr = (state == ST_ARMED);

  i2cw_shift #(.W(ADDR_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(shift_clr), .shift_en(shift_en),
    .bit_in(sda_i), .data(shift_data), .full(shift_full)
  );

  assign fire_evt      = (state == ST_ACK) && scl_fall && fire_ready(ack_clk_en, ack_seen);
  assign bad_start_evt = (state == ST_ARMED) && scl_fall && !start_ok;

  assign irq_set = {fire_evt, fire_evt || bad_start_evt};
  assign irq_clr = {clr_bus_irq, clr_pin_irq};

  i2cw_irq #(.N(2)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .req(irq_req)
  );

  assign pin_irq  = irq_req[0];
  assign bus_irq  = irq_req[1];
  assign scl_hold = (state == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      osc_req  <= 1'b0;
      ack_seen <= 1'b0;
      addr_o   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (wake_en && start_evt) begin
          state   <= ST_ARMED;
          osc_req <= 1'b1;
        end
        ST_ARMED: begin
          if (stop_evt) begin
            state   <= ST_IDLE;
            osc_req <= 1'b0;
          end else if (scl_fall) begin
            if (start_ok) state <= ST_SHIFT;
            else begin
              state   <= ST_IDLE;
              osc_req <= 1'b0;
            end
          end
        end
        ST_SHIFT: begin
          if (stop_evt) begin
            state   <= ST_IDLE;
            osc_req <= 1'b0;
          end else if (shift_full) begin
            state    <= ST_ACK;
            ack_seen <= 1'b0;
          end
        end
        ST_ACK: begin
          if (scl_rise) ack_seen <= 1'b1;
          if (fire_evt) begin
            state  <= ST_HOLD;
            addr_o <= shift_data;
          end
        end
        ST_HOLD: if (hold_release) begin
          state   <= ST_IDLE;
          osc_req <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !wake_en) |=> (state == ST_IDLE && !osc_req));
  // R7
  irq_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire_evt |=> (pin_irq && bus_irq && scl_hold));
  // R8
  hold_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> osc_req);
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && hold_release) |=> (!scl_hold && !osc_req));
  // R10
  stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SHIFT && stop_evt && !bus_irq) |=> (!bus_irq && !osc_req));
  // R9
  bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_start_evt |=> (pin_irq && $stable(addr_o) && !osc_req));
endmodule

// File: tb/sim_i2c_wake_rx.sv
module sim_i2c_wake_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1;
  logic wake_en = 1'b0, ack_clk_en = 1'b0, start_ok = 1'b1;
  logic hold_release = 1'b0, clr_pin_irq = 1'b0, clr_bus_irq = 1'b0;
  logic osc_req, pin_irq, bus_irq, scl_hold;
  logic [7:0] addr_o;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  i2c_wake_rx u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .wake_en(wake_en),
    .ack_clk_en(ack_clk_en), .start_ok(start_ok), .hold_release(hold_release),
    .clr_pin_irq(clr_pin_irq), .clr_bus_irq(clr_bus_irq), .osc_req(osc_req),
    .addr_o(addr_o), .pin_irq(pin_irq), .bus_irq(bus_irq), .scl_hold(scl_hold)
  );

  // {address, ack clock enable}
  localparam logic [8:0] VEC [4] = '{
    {8'hA5, 1'b0}, {8'h3C, 1'b1}, {8'h81, 1'b0}, {8'h1E, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic d);
    @(negedge clk);
    scl_i = c;
    sda_i = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_release();
    @(negedge clk); hold_release = 1'b1;
    @(negedge clk); hold_release = 1'b0;
    #1;
  endtask

  task automatic clear_irqs(input logic p, input logic b);
    @(negedge clk); clr_pin_irq = p; clr_bus_irq = b;
    @(negedge clk); clr_pin_irq = 1'b0; clr_bus_irq = 1'b0;
    #1;
  endtask

  task automatic bus_start();
    drive(1'b1, 1'b1); idle(1);
    drive(1'b1, 1'b0);
  endtask

  task automatic send_bit(input logic b);
    drive(1'b0, b); idle(1);
    drive(1'b1, b); idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    check("R1 osc_req", {7'd0, osc_req}, 8'd0);
    check("R1 irqs", {6'd0, pin_irq, bus_irq}, 8'd0);
    check("R1 scl_hold", {7'd0, scl_hold}, 8'd0);
    check("R1 addr_o", addr_o, 8'h00);
    rst_n = 1'b1;
    idle(2);

    // R2 disabled: START and clocks produce nothing
    bus_start();
    idle(1);
    check("R2 osc_req", {7'd0, osc_req}, 8'd0);
    for (int i = 0; i < 9; i++) send_bit(1'b1);
    drive(1'b0, 1'b1);
    idle(2);
    check("R2 irqs", {6'd0, pin_irq, bus_irq}, 8'd0);
    wake_en = 1'b1;

    // table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < 4; v++) begin
      logic [7:0] a;
      logic ak;
      a = VEC[v][8:1];
      ak = VEC[v][0];
      ack_clk_en = ak;
      bus_start();
      check("R3 osc_req after START", {7'd0, osc_req}, 8'd1);
      for (int i = 7; i >= 0; i--) send_bit(a[i]);
      if (ak) begin
        drive(1'b0, 1'b0);
        check("R6 no irq after 8th bit", {6'd0, pin_irq, bus_irq}, 8'd0);
        idle(1);
        drive(1'b1, 1'b0); idle(1);
        check("R6 no irq before ack fall", {6'd0, pin_irq, bus_irq}, 8'd0);
      end
      @(negedge clk); scl_i = 1'b0;
      @(posedge clk); #1;
      check("R7 irqs same cycle", {6'd0, pin_irq, bus_irq}, 8'd3);
      check(ak ? "R6 fire after ack" : "R5 fire after 8th bit", {7'd0, bus_irq}, 8'd1);
      check("R4 address", addr_o, a);
      check("R8 scl_hold set", {7'd0, scl_hold}, 8'd1);
      idle(4);
      check("R8 still holding", {7'd0, scl_hold}, 8'd1);
      pulse_release();
      check("R8 release", {6'd0, scl_hold, osc_req}, 8'd0);
      clear_irqs(1'b1, 1'b1);
      check("R11 both cleared", {6'd0, pin_irq, bus_irq}, 8'd0);
    end

    // R11 independent clears
    ack_clk_en = 1'b0;
    bus_start();
    for (int i = 7; i >= 0; i--) send_bit(1'b0);
    drive(1'b0, 1'b0);
    idle(1);
    pulse_release();
    clear_irqs(1'b1, 1'b0);
    check("R11 pin cleared only", {6'd0, pin_irq, bus_irq}, 8'd1);
    clear_irqs(1'b0, 1'b1);
    check("R11 bus cleared", {6'd0, pin_irq, bus_irq}, 8'd0);

    // R9 short START: pin irq only, address kept
    start_ok = 1'b0;
    bus_start();
    drive(1'b0, 1'b0);
    check("R9 irqs", {6'd0, pin_irq, bus_irq}, 8'd2);
    check("R9 osc_req", {7'd0, osc_req}, 8'd0);
    check("R9 addr kept", addr_o, 8'h00);
    start_ok = 1'b1;
    clear_irqs(1'b1, 1'b0);

    // R10 STOP in the middle of the address
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    drive(1'b0, 1'b0); idle(1);
    drive(1'b1, 1'b0); idle(1);
    drive(1'b1, 1'b1); idle(1);
    check("R10 osc_req", {7'd0, osc_req}, 8'd0);
    check("R10 irqs", {6'd0, pin_irq, bus_irq}, 8'd0);
    check("R10 scl_hold", {7'd0, scl_hold}, 8'd0);
    for (int i = 0; i < 9; i++) send_bit(1'b1);
    drive(1'b0, 1'b1); idle(2);
    check("R10 stays idle", {6'd0, pin_irq, bus_irq}, 8'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule